// File: doc/BRIEF.md
# Serial Configuration Register Target

This block receives a configuration word from a host over a three-wire serial link made of a strobe, a data line and a frame-start line. All three are sampled by the block's own clock. A frame starts when the frame line is pulsed low and then released. The next strobes shift the word in, most significant bit first. The strobes after that return the received word on the serial output, again most significant bit first, so the host can compare it against what it sent. One more strobe then commits the word to the active configuration register. Only that last strobe changes what the block drives.

The active word sets the direction of each header pin, enables a small set of mux switches and drives a few indicator LEDs. The fields, from bit 0 upward, are the pin directions, then the mux enables, then the LED drives. A separate output-enable line holds every pin as an input and turns all switches and LEDs off until the host has loaded a valid word and raises it. The shift register and the active register are separate, so a frame that stops partway leaves the active configuration untouched. Strobes that arrive after the commit are ignored until the next frame pulse.

Top module: `serial_cfg_target`

## Requirements
- R1: After power-on reset the active word is 0x00FFFFFFF: bits 0 to 27 are set, so every pin reads as an input, and all mux and LED bits are clear. The serial output is 0.
- R2: In a complete frame, the first 34 strobe rising edges shift in the data line most significant bit first, and the word sent is the word that is committed.
- R3: Strobe rising edges 35 to 68 of a frame each put one bit of the received word on the serial output, most significant bit first. Each bit is stable after its strobe until the next strobe.
- R4: The active word does not change during the load or readback strobes. It takes the received word on strobe 69 of the frame.
- R5: Strobe edges after the commit strobe change neither the active word nor the serial output until the next frame pulse.
- R6: A frame cut short by a new frame pulse leaves the active word unchanged, and the frame that follows loads normally.
- R7: While the frame line is held low, strobe edges have no effect and the bit counter stays at zero.
- R8: With output-enable high, the pin direction outputs equal active bits 27:0 (1 means input), the mux enables equal bits 30:28, and the LED drives equal bits 33:31.
- R9: With output-enable low, all pin direction outputs are 1 and all mux enable and LED outputs are 0, whatever the active word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all link inputs |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_stb | input | 1 | Serial strobe; rising edges advance the frame |
| cfg_frame_n | input | 1 | Frame line; a low pulse restarts the frame counter |
| cfg_sdi | input | 1 | Serial data in |
| out_en | input | 1 | Enables pin, mux and LED outputs from the active word |
| cfg_sdo | output | 1 | Serial readback data out |
| active_word | output | 34 | Committed configuration word |
| pin_is_input | output | 28 | Per-pin direction, 1 = input |
| mux_en | output | 3 | Mux switch enables |
| led_drv | output | 3 | LED drive outputs |

## Verification
The bench builds the block with its default field sizes: 28 pins, 3 mux switches and 3 LEDs, a 34-bit word and two synchroniser stages. These values make the full frame 69 strobes long and put the commit on strobe 69. The tests can therefore reach the exact load-to-readback and readback-to-commit boundaries, and each mux and LED field bit can be tied to its own output. Strobes are slow compared with the clock, so the synchroniser delay never merges two edges.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_READ  = 2'd1,
    PH_LATCH = 2'd2,
    PH_DONE  = 2'd3
  } scfg_phase_e;

  function automatic int unsigned word_width(int unsigned pins, int unsigned muxes,
                                             int unsigned leds);
    return pins + muxes + leds;
  endfunction

endpackage

// File: rtl/scfg_in_sync.sv
module scfg_in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/scfg_frame_ctrl.sv
module scfg_frame_ctrl
  import scfg_pkg::*;
#(
  parameter int unsigned WORD_W = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_rise,
  input  logic frame_ok,
  output logic load_en,
  output logic read_en,
  output logic latch_en
);

  localparam int unsigned CW = $clog2(2 * WORD_W + 2);
  localparam logic [CW-1:0] READ_START = CW'(WORD_W);
  localparam logic [CW-1:0] LATCH_AT   = CW'(2 * WORD_W);
  localparam logic [CW-1:0] DONE_AT    = CW'(2 * WORD_W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  scfg_phase_e   phase;
  logic          step;

  always_comb begin
    if (cnt_q < READ_START)     phase = PH_LOAD;
    else if (cnt_q < LATCH_AT)  phase = PH_READ;
    else if (cnt_q == LATCH_AT) phase = PH_LATCH;
    else                        phase = PH_DONE;
  end

  assign step = stb_rise && frame_ok && (phase != PH_DONE);

  always_comb begin
    cnt_d = cnt_q;
    if (!frame_ok)  cnt_d = '0;
    else if (step)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign load_en  = step && (phase == PH_LOAD);
  assign read_en  = step && (phase == PH_READ);
  assign latch_en = step && (phase == PH_LATCH);

  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> cnt_q == '0);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cnt_q == DONE_AT) |=> cnt_q == DONE_AT);

  // R4
  one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, read_en, latch_en}));

endmodule

// File: rtl/scfg_shift_path.sv
module scfg_shift_path #(
  parameter int unsigned WORD_W = 34,
  parameter logic [WORD_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              load_en,
  input  logic              read_en,
  input  logic              latch_en,
  output logic              sdo,
  output logic [WORD_W-1:0] active
);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] active_q, active_d;
  logic              sdo_q, sdo_d;

  // The readback rotates the shift register, so after all readback strobes
  // it again holds the received word in its original order.
  always_comb begin
    shreg_d = shreg_q;
    sdo_d   = sdo_q;
    if (load_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], sdi};
    end else if (read_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], shreg_q[WORD_W-1]};
      sdo_d   = shreg_q[WORD_W-1];
    end
  end

  always_comb begin
    active_d = active_q;
    if (latch_en) active_d = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      sdo_q    <= 1'b0;
      active_q <= INIT_WORD;
    end else begin
      shreg_q  <= shreg_d;
      sdo_q    <= sdo_d;
      active_q <= active_d;
    end
  end

  assign sdo    = sdo_q;
  assign active = active_q;

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(active_q));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en |=> $stable(sdo_q));

endmodule

// File: rtl/scfg_out_map.sv
module scfg_out_map #(
  parameter int unsigned PIN_CNT = 28,
  parameter int unsigned MUX_CNT = 3,
  parameter int unsigned LED_CNT = 3,
  parameter int unsigned WORD_W  = PIN_CNT + MUX_CNT + LED_CNT
) (
  input  logic [WORD_W-1:0]  active,
  input  logic               enable,
  output logic [PIN_CNT-1:0] pin_is_input,
  output logic [MUX_CNT-1:0] mux_en,
  output logic [LED_CNT-1:0] led_drv
);

  localparam int unsigned MUX_LSB = PIN_CNT;
  localparam int unsigned LED_LSB = PIN_CNT + MUX_CNT;

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    assign pin_is_input[p] = enable ? active[p] : 1'b1;
  end

  for (genvar m = 0; m < MUX_CNT; m++) begin : g_mux
    assign mux_en[m] = enable & active[MUX_LSB + m];
  end

  for (genvar l = 0; l < LED_CNT; l++) begin : g_led
    assign led_drv[l] = enable & active[LED_LSB + l];
  end

endmodule

// File: rtl/serial_cfg_target.sv
module serial_cfg_target
  import scfg_pkg::*;
#(
  parameter int unsigned PIN_CNT     = 28,
  parameter int unsigned MUX_CNT     = 3,
  parameter int unsigned LED_CNT     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_stb,
  input  logic                                         cfg_frame_n,
  input  logic                                         cfg_sdi,
  input  logic                                         out_en,
  output logic                                         cfg_sdo,
  output logic [word_width(PIN_CNT, MUX_CNT, LED_CNT)-1:0] active_word,
  output logic [PIN_CNT-1:0]                           pin_is_input,
  output logic [MUX_CNT-1:0]                           mux_en,
  output logic [LED_CNT-1:0]                           led_drv
);

  localparam int unsigned WORD_W = word_width(PIN_CNT, MUX_CNT, LED_CNT);
  localparam logic [WORD_W-1:0] INIT_WORD = {{(WORD_W-PIN_CNT){1'b0}}, {PIN_CNT{1'b1}}};
  localparam int unsigned MUX_LSB = PIN_CNT;
  localparam int unsigned LED_LSB = PIN_CNT + MUX_CNT;

  // Synchronised link inputs: {oe, sdi, frame_n, stb}
  logic [3:0] raw_in, sync_in;
  logic       stb_s, frame_s, sdi_s, oe_s;
  logic       stb_prev_q;
  logic       stb_rise;
  logic       load_en, read_en, latch_en;

  assign raw_in = {out_en, cfg_sdi, cfg_frame_n, cfg_stb};

  scfg_in_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0000)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_out (sync_in)
  );

  assign stb_s   = sync_in[0];
  assign frame_s = sync_in[1];
  assign sdi_s   = sync_in[2];
  assign oe_s    = sync_in[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev_q <= 1'b0;
    else        stb_prev_q <= stb_s;
  end

  assign stb_rise = stb_s & ~stb_prev_q;

  scfg_frame_ctrl #(
    .WORD_W (WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_rise (stb_rise),
    .frame_ok (frame_s),
    .load_en  (load_en),
    .read_en  (read_en),
    .latch_en (latch_en)
  );

  scfg_shift_path #(
    .WORD_W    (WORD_W),
    .INIT_WORD (INIT_WORD)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdi      (sdi_s),
    .load_en  (load_en),
    .read_en  (read_en),
    .latch_en (latch_en),
    .sdo      (cfg_sdo),
    .active   (active_word)
  );

  scfg_out_map #(
    .PIN_CNT (PIN_CNT),
    .MUX_CNT (MUX_CNT),
    .LED_CNT (LED_CNT),
    .WORD_W  (WORD_W)
  ) u_map (
    .active       (active_word),
    .enable       (oe_s),
    .pin_is_input (pin_is_input),
    .mux_en       (mux_en),
    .led_drv      (led_drv)
  );

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_s |-> ((&pin_is_input) && (mux_en == '0) && (led_drv == '0)));

  // R8
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_s |-> (pin_is_input == active_word[PIN_CNT-1:0]) &&
             (mux_en == active_word[MUX_LSB +: MUX_CNT]) &&
             (led_drv == active_word[LED_LSB +: LED_CNT]));

  // R7
  frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_s |-> !(load_en || read_en || latch_en));

endmodule

// File: tb/serial_cfg_target_test.sv
`timescale 1ns/1ps
module serial_cfg_target_test;

  localparam int W = 34;
  localparam logic [W-1:0] INIT = 34'h0_0FFF_FFFF;
  localparam int NV = 5;
  localparam logic [W-1:0] VECS [NV] = '{
    34'h3_0000_0001, 34'h1_2345_6789, 34'h2_5555_5555,
    34'h0_0000_0000, 34'h3_FFFF_FFFF
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_stb, cfg_frame_n, cfg_sdi, out_en;
  logic cfg_sdo;
  logic [W-1:0] active_word;
  logic [27:0] pin_is_input;
  logic [2:0] mux_en, led_drv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_cfg_target uut (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_frame_n(cfg_frame_n),
    .cfg_sdi(cfg_sdi), .out_en(out_en), .cfg_sdo(cfg_sdo),
    .active_word(active_word), .pin_is_input(pin_is_input),
    .mux_en(mux_en), .led_drv(led_drv)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic b);
    cfg_sdi = b;
    cfg_stb = 1'b0;
    wait_cyc(6);
    cfg_stb = 1'b1;
    wait_cyc(6);
  endtask

  task automatic frame_pulse();
    cfg_stb = 1'b0;
    cfg_frame_n = 1'b0;
    wait_cyc(6);
    cfg_frame_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) strobe(w[i]);
  endtask

  task automatic read_word(output logic [W-1:0] got);
    got = '0;
    for (int i = W - 1; i >= 0; i--) begin
      strobe(1'b0);
      got[i] = cfg_sdo;
    end
  endtask

  task automatic check_fields(input string req, input logic [W-1:0] w);
    check(req, {6'd0, pin_is_input}, {6'd0, w[27:0]});
    check(req, {31'd0, mux_en}, {31'd0, w[30:28]});
    check(req, {31'd0, led_drv}, {31'd0, w[33:31]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_active;
    logic [W-1:0] got;
    logic last_sdo;
    rst_n = 1'b0;
    cfg_stb = 1'b0;
    cfg_frame_n = 1'b1;
    cfg_sdi = 1'b0;
    out_en = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: reset state
    check("R1 active", active_word, INIT);
    check("R1 sdo", {33'd0, cfg_sdo}, '0);
    out_en = 1'b1;
    wait_cyc(6);
    check_fields("R1/R8 fields", INIT);
    exp_active = INIT;

    // Vector table: full frames
    for (int v = 0; v < NV; v++) begin
      frame_pulse();
      load_word(VECS[v]);
      check("R4 after load", active_word, exp_active);
      read_word(got);
      check("R3 readback", got, VECS[v]);
      check("R4 after readback", active_word, exp_active);
      strobe(1'b0);
      exp_active = VECS[v];
      check("R2 committed", active_word, exp_active);
      check_fields("R8 fields", exp_active);
    end

    // R5: strobes after commit ignored
    last_sdo = cfg_sdo;
    for (int k = 0; k < 6; k++) strobe(k[0]);
    check("R5 active", active_word, exp_active);
    check("R5 sdo", {33'd0, cfg_sdo}, {33'd0, last_sdo});

    // R6: aborted frame
    frame_pulse();
    for (int k = 0; k < 10; k++) strobe(1'b0);
    frame_pulse();
    check("R6 aborted", active_word, exp_active);
    load_word(34'h1_A5C3_0F96);
    read_word(got);
    check("R6 readback", got, 34'h1_A5C3_0F96);
    strobe(1'b1);
    exp_active = 34'h1_A5C3_0F96;
    check("R6 reload", active_word, exp_active);

    // R7: frame line held low
    cfg_frame_n = 1'b0;
    wait_cyc(6);
    for (int k = 0; k < 2 * W + 1; k++) strobe(1'b0);
    check("R7 held", active_word, exp_active);
    cfg_frame_n = 1'b1;
    wait_cyc(6);
    load_word(34'h2_0F0F_3C3C);
    read_word(got);
    check("R7 readback", got, 34'h2_0F0F_3C3C);
    strobe(1'b0);
    exp_active = 34'h2_0F0F_3C3C;
    check("R7 count from zero", active_word, exp_active);

    // R9: output enable low
    out_en = 1'b0;
    wait_cyc(6);
    check("R9 pins", {6'd0, pin_is_input}, {6'd0, 28'hFFF_FFFF});
    check("R9 mux", {31'd0, mux_en}, '0);
    check("R9 led", {31'd0, led_drv}, '0);
    check("R9 active kept", active_word, exp_active);
    out_en = 1'b1;
    wait_cyc(6);
    check_fields("R8 re-enabled", exp_active);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule